// File: doc/BRIEF.md
# Shared-Resource Multicycle Datapath

This block is the data side of a small 32-bit processor that runs each instruction over several clock steps. One ALU does every computation: the next program counter, the branch target, the load or store address and the arithmetic result. One memory holds both instructions and data. Holding registers carry values from one step to the next: the instruction register, the memory data register, two operand registers and the ALU result register. The block covers register-register add, subtract, and, or, word load, word store, branch-if-equal and jump.

The block does not sequence itself. An external controller drives every enable and select in each step. The block returns the opcode field of the held instruction and the ALU zero flag to that controller. A preload port writes words into the memory so that programs and data can be placed before execution. For observation, the program counter and the live ALU result are also brought out.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 on the next clock edge.
- R2: At a clock edge with `ir_load` high, the instruction register takes the memory word at the current memory address. With `ir_load` low it keeps its value. `opcode` always shows bits 31:26 of the instruction register.
- R3: The memory address is the program counter when `mem_addr_sel` is 0 and the ALU result register when it is 1. The memory data register takes the memory read data at every edge. With `mem_wr_en` high, the B operand register is written to memory at that address. Words are indexed by address bits above bit 1.
- R4: At every edge, operand register A takes the register numbered by instruction bits 25:21, and B takes the register numbered by bits 20:16. At every edge, the ALU result register takes the current ALU result.
- R5: The ALU first input is the program counter when `alu_a_sel` is 0 and register A when it is 1. The second input depends on `alu_b_sel`: B for 00, the constant 4 for 01, the sign-extended instruction bits 15:0 for 10, and that value shifted left by two for 11.
- R6: `alu_func` gives the operation: 010 add, 110 subtract, 000 and, 001 or. Any other code gives 0. `alu_zero` is 1 exactly when the ALU result is all zeros.
- R7: The program counter loads at an edge when `pc_load` is high, or when `pc_cond_load` is high and `alu_zero` is 1. Otherwise it holds. `pc_src_sel` chooses the new value: 00 takes the live ALU result, 01 the ALU result register, 10 the jump address.
- R8: The jump address is program counter bits 31:28, then instruction bits 25:0, then two zero bits.
- R9: With `rf_wr_en` high, the register file is written at the edge. The destination is instruction bits 20:16 when `dst_sel` is 0 and bits 15:11 when it is 1. The data is the ALU result register when `wb_sel` is 0 and the memory data register when it is 1.
- R10: Register 0 always reads as zero. A write to it has no effect.
- R11: With `boot_we` high, `boot_wdata` is written to memory at `boot_addr`. This takes priority over the datapath address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_we | input | 1 | Memory preload write enable |
| boot_addr | input | 32 | Memory preload byte address |
| boot_wdata | input | 32 | Memory preload data |
| mem_addr_sel | input | 1 | Memory address source: 0 program counter, 1 ALU result register |
| ir_load | input | 1 | Instruction register load enable |
| mem_wr_en | input | 1 | Store enable |
| pc_load | input | 1 | Unconditional program counter load |
| pc_cond_load | input | 1 | Program counter load when zero flag is set |
| rf_wr_en | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination field select |
| wb_sel | input | 1 | Write-back data select |
| alu_a_sel | input | 1 | ALU first input select |
| alu_b_sel | input | 2 | ALU second input select |
| pc_src_sel | input | 2 | Program counter source select |
| alu_func | input | 3 | ALU operation code |
| opcode | output | 6 | Instruction register bits 31:26 |
| alu_zero | output | 1 | ALU result is zero |
| pc_q | output | 32 | Program counter |
| alu_result | output | 32 | Live ALU result |

## Verification
The bench builds the block with its defaults: a 64-word memory and 32 registers. With these, every code and data address stays inside a single memory image, and the bench can follow the whole state in a small model. The bench acts as the controller and steps each instruction kind through its full sequence. It sweeps add, subtract, and and or over every pair drawn from six boundary operands, including zero, all ones, the sign bit alone and the largest positive value. Register contents are read back by issuing a probe instruction and observing the ALU result. This path brings the operand latching, write-back selection, register 0 behaviour and store data all within reach at the ports.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int DW = 32;

  localparam logic [2:0] FN_AND = 3'b000;
  localparam logic [2:0] FN_OR  = 3'b001;
  localparam logic [2:0] FN_ADD = 3'b010;
  localparam logic [2:0] FN_SUB = 3'b110;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_HOLD = 2'b01;
  localparam logic [1:0] PCS_JUMP = 2'b10;

  function automatic logic [DW-1:0] alu_calc(input logic [2:0] fn,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    logic [DW-1:0] r;
    case (fn)
      FN_ADD:  r = x + y;
      FN_SUB:  r = x - y;
      FN_AND:  r = x & y;
      FN_OR:   r = x | y;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] sext16(input logic [15:0] v);
    return {{(DW-16){v[15]}}, v};
  endfunction

  function automatic logic [DW-1:0] jump_addr(input logic [DW-1:0] pc,
                                              input logic [25:0] idx);
    return {pc[DW-1:DW-4], idx, 2'b00};
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [2:0]    fn,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic [DW-1:0] result,
  output logic          zero
);
  always_comb begin
    result = alu_calc(fn, in_a, in_b);
    zero   = (result == '0);
  end

  // R6: subtracting equal operands must flag zero
  always_comb begin
    if (fn == FN_SUB && in_a == in_b)
      a_r6_sub_equal_zero: assert (zero);
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int REG_COUNT = 32,
  localparam int RAW = $clog2(REG_COUNT)
) (
  input  logic           clk,
  input  logic [RAW-1:0] ra,
  input  logic [RAW-1:0] rb,
  output logic [DW-1:0]  rd_a,
  output logic [DW-1:0]  rd_b,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [DW-1:0]  wd
);
  logic [DW-1:0] regs [REG_COUNT];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd_a = (ra == '0) ? '0 : regs[ra];
  assign rd_b = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mc_memory.sv
module mc_memory
  import mc_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
  end

  assign rdata = store[idx];

  // R3 / R11: a write lands at the addressed word
  a_r3_store_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> store[$past(idx)] == $past(wdata));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int REG_COUNT = 32,
  localparam int IW  = $clog2(MEM_WORDS),
  localparam int RAW = $clog2(REG_COUNT)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        boot_we,
  input  logic [31:0] boot_addr,
  input  logic [31:0] boot_wdata,
  input  logic        mem_addr_sel,
  input  logic        ir_load,
  input  logic        mem_wr_en,
  input  logic        pc_load,
  input  logic        pc_cond_load,
  input  logic        rf_wr_en,
  input  logic        dst_sel,
  input  logic        wb_sel,
  input  logic        alu_a_sel,
  input  logic [1:0]  alu_b_sel,
  input  logic [1:0]  pc_src_sel,
  input  logic [2:0]  alu_func,
  output logic [5:0]  opcode,
  output logic        alu_zero,
  output logic [31:0] pc_q,
  output logic [31:0] alu_result
);
  logic [DW-1:0] pc_r, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
  logic          mem_we;
  logic [DW-1:0] rf_a, rf_b, wb_data;
  logic [RAW-1:0] wb_reg;
  logic [DW-1:0] alu_x, alu_y, imm_ext, pc_next;
  logic          pc_en;

  // memory port: preload has priority over the datapath
  assign mem_addr  = boot_we ? boot_addr  : (mem_addr_sel ? aluout_q : pc_r);
  assign mem_wdata = boot_we ? boot_wdata : b_q;
  assign mem_we    = boot_we | mem_wr_en;

  mc_memory #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .rst(rst), .idx(mem_addr[IW+1:2]), .we(mem_we),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  // register file with write-back selection
  assign wb_reg  = dst_sel ? ir_q[11+RAW-1:11] : ir_q[16+RAW-1:16];
  assign wb_data = wb_sel ? mdr_q : aluout_q;

  mc_regfile #(.REG_COUNT(REG_COUNT)) u_rf (
    .clk(clk), .ra(ir_q[21+RAW-1:21]), .rb(ir_q[16+RAW-1:16]),
    .rd_a(rf_a), .rd_b(rf_b), .we(rf_wr_en), .wa(wb_reg), .wd(wb_data)
  );

  // ALU operand selection
  assign imm_ext = sext16(ir_q[15:0]);
  assign alu_x   = alu_a_sel ? a_q : pc_r;
  always_comb begin
    case (alu_b_sel)
      2'b00:   alu_y = b_q;
      2'b01:   alu_y = 32'd4;
      2'b10:   alu_y = imm_ext;
      default: alu_y = {imm_ext[DW-3:0], 2'b00};
    endcase
  end

  mc_alu u_alu (
    .fn(alu_func), .in_a(alu_x), .in_b(alu_y),
    .result(alu_result), .zero(alu_zero)
  );

  // program counter source and enable
  always_comb begin
    case (pc_src_sel)
      PCS_HOLD: pc_next = aluout_q;
      PCS_JUMP: pc_next = jump_addr(pc_r, ir_q[25:0]);
      default:  pc_next = alu_result;
    endcase
  end
  assign pc_en = pc_load | (pc_cond_load & alu_zero);

  always_ff @(posedge clk) begin
    if (rst)        pc_r <= '0;
    else if (pc_en) pc_r <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ir_load) ir_q <= mem_rdata;
    mdr_q    <= mem_rdata;
    a_q      <= rf_a;
    b_q      <= rf_b;
    aluout_q <= alu_result;
  end

  assign opcode = ir_q[31:26];
  assign pc_q   = pc_r;

  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> pc_r == '0);

  a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_en |=> $stable(pc_r));

  a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(ir_q));

  a_r10_zero_reg: assert property (@(posedge clk) disable iff (rst)
    ir_q[25:21] == 5'd0 |=> a_q == '0);
endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        boot_we;
  logic [31:0] boot_addr, boot_wdata;
  logic        mem_addr_sel, ir_load, mem_wr_en, pc_load, pc_cond_load;
  logic        rf_wr_en, dst_sel, wb_sel, alu_a_sel;
  logic [1:0]  alu_b_sel, pc_src_sel;
  logic [2:0]  alu_func;
  logic [5:0]  opcode;
  logic        alu_zero;
  logic [31:0] pc_q, alu_result;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] pc_m;
  logic [31:0] rf_m [32];
  logic [31:0] vals [6];

  always #5 clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk(clk), .rst(rst), .boot_we(boot_we), .boot_addr(boot_addr),
    .boot_wdata(boot_wdata), .mem_addr_sel(mem_addr_sel), .ir_load(ir_load),
    .mem_wr_en(mem_wr_en), .pc_load(pc_load), .pc_cond_load(pc_cond_load),
    .rf_wr_en(rf_wr_en), .dst_sel(dst_sel), .wb_sel(wb_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .pc_src_sel(pc_src_sel),
    .alu_func(alu_func), .opcode(opcode), .alu_zero(alu_zero),
    .pc_q(pc_q), .alu_result(alu_result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_alu(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    if (f == 3'b010) return x + y;
    if (f == 3'b110) return x + (~y) + 32'd1;
    if (f == 3'b000) return ~(~x | ~y);
    if (f == 3'b001) return ~(~x & ~y);
    return 32'd0;
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic idle();
    boot_we = 0; boot_addr = 0; boot_wdata = 0; mem_addr_sel = 0; ir_load = 0;
    mem_wr_en = 0; pc_load = 0; pc_cond_load = 0; rf_wr_en = 0; dst_sel = 0;
    wb_sel = 0; alu_a_sel = 0; alu_b_sel = 0; pc_src_sel = 0; alu_func = 3'b000;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic boot(input logic [31:0] addr, input logic [31:0] data);
    idle(); boot_we = 1; boot_addr = addr; boot_wdata = data;
    tick(); idle();
  endtask

  task automatic fetch_decode();
    idle(); ir_load = 1; alu_b_sel = 2'b01; alu_func = 3'b010; pc_load = 1;
    #1 check("R5 pc plus four", alu_result, pc_m + 32'd4);
    tick(); pc_m = pc_m + 32'd4;
    idle(); alu_b_sel = 2'b11; alu_func = 3'b010;
    tick(); idle();
  endtask

  task automatic jump_exec(input logic [25:0] idx);
    idle(); pc_load = 1; pc_src_sel = 2'b10;
    tick(); idle();
    pc_m = {pc_m[31:28], idx, 2'b00};
  endtask

  // place an instruction at the PC, fetch and decode it; recentre code when near data
  task automatic run(input logic [31:0] instr);
    if (pc_m[7:0] >= 8'd184) begin
      boot(pc_m, {6'd2, 26'd0});
      fetch_decode();
      jump_exec(26'd0);
    end
    boot(pc_m, instr);
    fetch_decode();
  endtask

  task automatic do_lw(input int rt, input logic [15:0] off);
    logic [31:0] d;
    run(enc_i(6'd35, 0, rt, off));
    idle(); alu_a_sel = 1; alu_b_sel = 2'b10; alu_func = 3'b010; tick();
    idle(); mem_addr_sel = 1; tick();
    idle(); rf_wr_en = 1; wb_sel = 1; tick(); idle();
  endtask

  task automatic do_sw(input int rt, input logic [15:0] off);
    run(enc_i(6'd43, 0, rt, off));
    idle(); alu_a_sel = 1; alu_b_sel = 2'b10; alu_func = 3'b010; tick();
    idle(); mem_addr_sel = 1; mem_wr_en = 1; tick(); idle();
  endtask

  task automatic do_r(input int rs, input int rt, input int rd, input logic [2:0] f);
    run(enc_r(rs, rt, rd));
    idle(); alu_a_sel = 1; alu_func = f; tick();
    idle(); rf_wr_en = 1; dst_sel = 1; tick(); idle();
    if (rd != 0) rf_m[rd] = model_alu(f, rf_m[rs], rf_m[rt]);
  endtask

  task automatic probe(input int r, input string req);
    run(enc_r(r, 0, r));
    idle(); alu_a_sel = 1; alu_func = 3'b001;
    #1;
    check(req, alu_result, rf_m[r]);
    check("R6 zero flag", {31'd0, alu_zero}, {31'd0, rf_m[r] == 32'd0});
    idle();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < 32; i++) rf_m[i] = 32'd0;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h1234_5678;
    rst = 1; tick(); tick(); rst = 0;
    pc_m = 0;
    check("R1 reset pc", pc_q, 32'd0);

    // R3 / R11: preload data words and load them
    for (int i = 0; i < 6; i++) boot(32'd224 + 32'(i*4), vals[i]);
    for (int i = 0; i < 6; i++) begin
      do_lw(i + 1, 16'(224 + i*4));
      rf_m[i+1] = vals[i];
    end
    for (int i = 1; i <= 6; i++) probe(i, "R3 R4 load then read back");
    check("R7 pc tracks sequence", pc_q, pc_m);

    // R6: operation sweep over operand pairs
    for (int f = 0; f < 4; f++) begin
      logic [2:0] fc;
      fc = (f == 0) ? 3'b010 : (f == 1) ? 3'b110 : (f == 2) ? 3'b000 : 3'b001;
      for (int i = 1; i <= 6; i++)
        for (int j = 1; j <= 6; j++) begin
          do_r(i, j, 7, fc);
          probe(7, "R6 alu operation");
        end
    end

    // R6: undefined code gives zero
    run(enc_r(2, 3, 0));
    idle(); alu_a_sel = 1; alu_func = 3'b111; #1;
    check("R6 undefined code", alu_result, 32'd0);
    idle();

    // R10: write to register 0 ignored
    do_r(3, 3, 0, 3'b010);
    probe(0, "R10 register zero");

    // R3: store then reload
    do_sw(6, 16'd248);
    do_lw(8, 16'd248);
    rf_m[8] = rf_m[6];
    probe(8, "R3 store data");

    // R9: R-type result written to the rt field with dst_sel 0
    run(enc_r(2, 8, 10));
    idle(); alu_a_sel = 1; alu_func = 3'b010; tick();
    idle(); rf_wr_en = 1; tick(); idle();
    rf_m[8] = rf_m[2] + rf_m[8];
    probe(8, "R9 destination select");

    // R7: branch taken
    begin
      logic [31:0] tgt;
      run(enc_i(6'd4, 1, 1, 16'd3));
      tgt = pc_m + 32'd12;
      idle(); alu_a_sel = 1; alu_func = 3'b110; pc_cond_load = 1; pc_src_sel = 2'b01;
      #1 check("R7 beq zero equal", {31'd0, alu_zero}, 32'd1);
      tick(); idle(); pc_m = tgt;
      check("R7 beq taken", pc_q, tgt);
    end

    // R7: branch not taken
    run(enc_i(6'd4, 1, 2, 16'd5));
    idle(); alu_a_sel = 1; alu_func = 3'b110; pc_cond_load = 1; pc_src_sel = 2'b01;
    tick(); idle();
    check("R7 beq not taken", pc_q, pc_m);

    // R8: jump
    run({6'd2, 26'd5});
    jump_exec(26'd5);
    check("R8 jump address", pc_q, 32'd20);

    // R2: opcode shown, held without ir_load
    run(enc_i(6'd35, 0, 1, 16'd224));
    check("R2 opcode", {26'd0, opcode}, 32'd35);
    boot(pc_m, enc_i(6'd43, 0, 1, 16'd0));
    idle(); tick();
    check("R2 ir hold", {26'd0, opcode}, 32'd35);

    // R1: reset mid-run
    rst = 1; tick(); rst = 0;
    check("R1 reset mid run", pc_q, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule